// File: doc/BRIEF.md
# Cache Line Refill and Victim Write-Back Engine

This block services one cache miss for a 32-byte line split into four 8-byte beats. When a miss is accepted and the line being replaced holds modified data, the victim's tag and all four data beats are parked in a one-line write-back buffer in the same clock edge. The replacement line is then read from external memory one beat per handshake. The first beat read is the one that holds the missed byte, and the following beats wrap around the line boundary. Each returned beat goes straight into the chosen way of the data array.

After the last beat, the engine writes the line's tag with its valid bit set. The dirty bit is set only when the miss came from a store that merges into the new line. In the next cycle the engine marks the filled way as most recently used. Only after that does the parked victim drain to memory, in ascending beat order, at an address rebuilt from the saved tag and the set index.

A demand miss stalls the requester until the critical beat arrives, which is flagged by a one-cycle pulse. A prefetch miss never stalls. No new miss is admitted while the buffer still holds a victim.

Top module: `line_refill_engine`

## Requirements
- R1: A dirty victim's tag and data are captured in the acceptance cycle. No memory write is issued before the new line's last beat has been read and the LRU update has been made.
- R2: The fill issues reads at beat addresses {line, (s+i) mod 4, 3'b000} for i = 0..3, where s is request address bits [4:3].
- R3: Each acknowledged read beat drives one data-array write, with the request's set (address bits [12:5]), the request's way, the beat number and the returned data.
- R4: `crit_valid_o` pulses for exactly one cycle, together with the first beat's array write, and at no other time.
- R5: On the last beat the tag array is written with address bits [31:13], valid = 1, and dirty = 1 only if the request was a store.
- R6: In the cycle after the last beat, `lru_upd_o` is high for one cycle with the filled set and way.
- R7: After the LRU update, a dirty victim drains as four writes in beat order 0,1,2,3, each at {victim tag, set, beat, 3'b000} with that beat's data (data input bits [64k+63:64k] for beat k).
- R8: `req_ready_o` is low while a fill is running and while the buffer holds a victim. A request raised during the drain is ignored: no read starts until the buffer is empty and the request is raised again.
- R9: For a demand miss, `cpu_stall_o` is high from the first fill cycle through the critical beat's cycle and low afterwards. For a prefetch miss it is never high.
- R10: A miss with a clean victim issues no memory write, and `req_ready_o` returns high in the cycle after the LRU update.
- R11: While `mem_req_o` is high and `mem_ack_i` is low, the request, address and array write enables hold.
- R12: During and after reset the engine is idle: ready high, with no memory request, stall, critical pulse or LRU update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Engine can accept a miss |
| req_addr_i | input | 32 | Missed physical address |
| req_way_i | input | 2 | Way chosen for replacement |
| req_victim_dirty_i | input | 1 | Victim line holds modified data |
| req_victim_tag_i | input | 19 | Victim line tag |
| req_victim_data_i | input | 256 | Victim line data, beat k at bits [64k+63:64k] |
| req_store_i | input | 1 | Miss comes from a store merged into the line |
| req_prefetch_i | input | 1 | Miss is a prefetch; do not stall |
| cpu_stall_o | output | 1 | Requester must wait |
| crit_valid_o | output | 1 | Critical beat is on arr_data_o this cycle |
| arr_data_we_o | output | 1 | Data array write enable |
| arr_set_o | output | 8 | Array set index |
| arr_way_o | output | 2 | Array way |
| arr_beat_o | output | 2 | Beat number within the line |
| arr_data_o | output | 64 | Beat data to array |
| arr_tag_we_o | output | 1 | Tag array write enable |
| arr_tag_o | output | 19 | Tag to write |
| arr_valid_o | output | 1 | Valid bit to write |
| arr_dirty_o | output | 1 | Dirty bit to write |
| lru_upd_o | output | 1 | Mark way as most recently used |
| lru_set_o | output | 8 | Set for the LRU update |
| lru_way_o | output | 2 | Way for the LRU update |
| mem_req_o | output | 1 | External memory beat request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Memory accepts the beat; read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
A wrong beat counter or start offset shows on `mem_addr_o` at the first or second fill beat. The same error appears in the same cycle on `arr_beat_o`, so an order fault surfaces within two beats of acceptance. A buffer that is captured late, or that drains early, shows a write on the memory port during the fill or the wrong victim beat on `mem_wdata_o` in the first drain cycle. An admission gate that ignores the buffer state shows a fill read starting while the drain is still in progress.

// File: rtl/lre_pkg.sv
package lre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_LRU  = 2'd2
  } lre_state_e;
endpackage

// File: rtl/lre_beat_seq.sv
module lre_beat_seq #(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else if (load_i) begin
      cnt_q   <= '0;
      start_q <= start_i;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-of-two beat count: wrap is free
  assign beat_o  = start_q + cnt_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST_CNT);

  AST_BEAT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !last_o |=> beat_o == $past(beat_o) + 1'b1); // R2
  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> first_o && beat_o == $past(start_i)); // R2
endmodule

// File: rtl/lre_wb_buf.sv
module lre_wb_buf #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 19,
  parameter int IDX_W  = 8,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  localparam int CNT_W  = $clog2(BEATS),
  localparam int BOFF_W = $clog2(BEAT_W / 8),
  localparam int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [LINE_W-1:0] data_i,
  input  logic              drain_en_i,
  input  logic              ack_i,
  output logic              full_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BEAT_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);

  logic                         full_q;
  logic [TAG_W-1:0]             tag_q;
  logic [IDX_W-1:0]             set_q;
  logic [BEATS-1:0][BEAT_W-1:0] data_q;
  logic [CNT_W-1:0]             idx_q;
  logic                         drain_ack;

  assign wr_req_o  = full_q & drain_en_i;
  assign drain_ack = wr_req_o & ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      tag_q  <= '0;
      set_q  <= '0;
      data_q <= '0;
      idx_q  <= '0;
    end else if (cap_i) begin
      full_q <= 1'b1;
      tag_q  <= tag_i;
      set_q  <= set_i;
      data_q <= data_i;
      idx_q  <= '0;
    end else if (drain_ack) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_CNT) full_q <= 1'b0;
    end
  end

  assign full_o    = full_q;
  assign wr_addr_o = {tag_q, set_q, idx_q, {BOFF_W{1'b0}}};
  assign wr_data_o = data_q[idx_q];

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !full_q); // R8
  AST_DRAIN_ASC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_ack && idx_q != LAST_CNT |=> full_q && idx_q == $past(idx_q) + 1'b1); // R7
endmodule

// File: rtl/line_refill_engine.sv
module line_refill_engine
  import lre_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8,
  parameter int SETS       = 256,
  parameter int WAYS       = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BOFF_W = $clog2(BEAT_BYTES),
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
  localparam int CNT_W  = $clog2(BEATS),
  localparam int BEAT_W = 8 * BEAT_BYTES,
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WAY_W-1:0]  req_way_i,
  input  logic              req_victim_dirty_i,
  input  logic [TAG_W-1:0]  req_victim_tag_i,
  input  logic [LINE_W-1:0] req_victim_data_i,
  input  logic              req_store_i,
  input  logic              req_prefetch_i,
  output logic              cpu_stall_o,
  output logic              crit_valid_o,
  output logic              arr_data_we_o,
  output logic [IDX_W-1:0]  arr_set_o,
  output logic [WAY_W-1:0]  arr_way_o,
  output logic [CNT_W-1:0]  arr_beat_o,
  output logic [BEAT_W-1:0] arr_data_o,
  output logic              arr_tag_we_o,
  output logic [TAG_W-1:0]  arr_tag_o,
  output logic              arr_valid_o,
  output logic              arr_dirty_o,
  output logic              lru_upd_o,
  output logic [IDX_W-1:0]  lru_set_o,
  output logic [WAY_W-1:0]  lru_way_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BEAT_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [BEAT_W-1:0] mem_rdata_i
);
  lre_state_e        state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic              store_q, pf_q;
  logic              accept, fill_ack;
  logic [CNT_W-1:0]  beat;
  logic              first, last;
  logic              wb_full, wb_req;
  logic [ADDR_W-1:0] wb_addr;
  logic [BEAT_W-1:0] wb_data;
  logic              unused_addr_bits;

  assign unused_addr_bits = ^req_addr_i[BOFF_W-1:0];

  assign req_ready_o = (state_q == ST_IDLE) & ~wb_full;
  assign accept      = req_valid_i & req_ready_o;
  assign fill_ack    = (state_q == ST_FILL) & mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      set_q   <= '0;
      way_q   <= '0;
      store_q <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_FILL;
          tag_q   <= req_addr_i[ADDR_W-1 -: TAG_W];
          set_q   <= req_addr_i[OFF_W +: IDX_W];
          way_q   <= req_way_i;
          store_q <= req_store_i;
          pf_q    <= req_prefetch_i;
        end
        ST_FILL: if (fill_ack && last) state_q <= ST_LRU;
        ST_LRU:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lre_beat_seq #(.BEATS(BEATS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .start_i (req_addr_i[BOFF_W +: CNT_W]),
    .adv_i   (fill_ack),
    .beat_o  (beat),
    .first_o (first),
    .last_o  (last)
  );

  // victim parked at acceptance; drains only once the fill and LRU update are done
  lre_wb_buf #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .IDX_W  (IDX_W),
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS)
  ) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (accept & req_victim_dirty_i),
    .tag_i      (req_victim_tag_i),
    .set_i      (req_addr_i[OFF_W +: IDX_W]),
    .data_i     (req_victim_data_i),
    .drain_en_i (state_q == ST_IDLE),
    .ack_i      (mem_ack_i),
    .full_o     (wb_full),
    .wr_req_o   (wb_req),
    .wr_addr_o  (wb_addr),
    .wr_data_o  (wb_data)
  );

  assign mem_req_o   = (state_q == ST_FILL) | wb_req;
  assign mem_we_o    = wb_req;
  assign mem_addr_o  = (state_q == ST_FILL) ? {tag_q, set_q, beat, {BOFF_W{1'b0}}} : wb_addr;
  assign mem_wdata_o = wb_data;

  assign arr_data_we_o = fill_ack;
  assign arr_set_o     = set_q;
  assign arr_way_o     = way_q;
  assign arr_beat_o    = beat;
  assign arr_data_o    = mem_rdata_i;
  assign arr_tag_we_o  = fill_ack & last;
  assign arr_tag_o     = tag_q;
  assign arr_valid_o   = 1'b1;
  assign arr_dirty_o   = store_q;

  assign crit_valid_o = fill_ack & first;
  assign cpu_stall_o  = (state_q == ST_FILL) & first & ~pf_q;

  assign lru_upd_o = (state_q == ST_LRU);
  assign lru_set_o = set_q;
  assign lru_way_o = way_q;

  AST_WB_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> state_q == ST_IDLE); // R1
  AST_CRIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |-> arr_data_we_o ##1 !crit_valid_o); // R4
  AST_LRU_AFTER_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_tag_we_o |=> lru_upd_o && !mem_req_o); // R6
  AST_READY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_full |-> !req_ready_o); // R8
  AST_STALL_DEMAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> !pf_q && !lru_upd_o); // R9
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
endmodule

// File: tb/line_refill_engine_tb.sv
module line_refill_engine_tb;
  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  way;
    logic        dirty;
    logic        store;
    logic        pf;
    logic [2:0]  hold;   // beat at which memory withholds ack one cycle; 4 = never
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1A48, 2'd1, 1'b1, 1'b0, 1'b0, 3'd2},
    '{32'h1234_5678, 2'd3, 1'b0, 1'b1, 1'b0, 3'd4},
    '{32'h8000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 3'd0},
    '{32'hFFFF_FFF0, 2'd2, 1'b0, 1'b0, 1'b1, 3'd3},
    '{32'h0040_2010, 2'd1, 1'b1, 1'b0, 1'b0, 3'd4},
    '{32'h0ABC_DEF8, 2'd2, 1'b1, 1'b1, 1'b0, 3'd1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_way = '0;
  logic         req_dirty = 1'b0;
  logic [18:0]  req_vtag = '0;
  logic [255:0] req_vdata = '0;
  logic         req_store = 1'b0;
  logic         req_pf = 1'b0;
  logic         ack_en = 1'b1;
  logic         req_ready_o, cpu_stall_o, crit_valid_o;
  logic         arr_data_we_o, arr_tag_we_o, arr_valid_o, arr_dirty_o, lru_upd_o;
  logic [7:0]   arr_set_o, lru_set_o;
  logic [1:0]   arr_way_o, arr_beat_o, lru_way_o;
  logic [63:0]  arr_data_o, mem_wdata_o, mem_rdata_i;
  logic [18:0]  arr_tag_o;
  logic         mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0]  mem_addr_o;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  assign mem_ack_i   = mem_req_o & ack_en;
  assign mem_rdata_i = {~mem_addr_o, mem_addr_o};

  line_refill_engine u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready_o), .req_addr_i (req_addr),
    .req_way_i (req_way), .req_victim_dirty_i (req_dirty), .req_victim_tag_i (req_vtag),
    .req_victim_data_i (req_vdata), .req_store_i (req_store), .req_prefetch_i (req_pf),
    .cpu_stall_o (cpu_stall_o), .crit_valid_o (crit_valid_o),
    .arr_data_we_o (arr_data_we_o), .arr_set_o (arr_set_o), .arr_way_o (arr_way_o),
    .arr_beat_o (arr_beat_o), .arr_data_o (arr_data_o), .arr_tag_we_o (arr_tag_we_o),
    .arr_tag_o (arr_tag_o), .arr_valid_o (arr_valid_o), .arr_dirty_o (arr_dirty_o),
    .lru_upd_o (lru_upd_o), .lru_set_o (lru_set_o), .lru_way_o (lru_way_o),
    .mem_req_o (mem_req_o), .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o),
    .mem_wdata_o (mem_wdata_o), .mem_ack_i (mem_ack_i), .mem_rdata_i (mem_rdata_i)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] vbeat(input int v, input int k, input logic [31:0] a);
    return {8'hC0, 8'(v), 16'(k), a ^ 32'h5555_AAAA};
  endfunction

  task automatic run_vec(input int v);
    vec_t t;
    logic [18:0] vt;
    logic [31:0] ea;
    t  = VECS[v];
    vt = t.addr[31:13] ^ 19'h2_A5A5;
    @(negedge clk);
    req_valid = 1'b1; req_addr = t.addr; req_way = t.way; req_dirty = t.dirty;
    req_store = t.store; req_pf = t.pf; req_vtag = vt;
    for (int k = 0; k < 4; k++) req_vdata[64*k +: 64] = vbeat(v, k, t.addr);
    #1 chk("R8 ready when idle", 64'(req_ready_o), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ea = {t.addr[31:5], 2'(t.addr[4:3] + 2'(i)), 3'b000};
      if (t.hold == 3'(i)) begin
        ack_en = 1'b0;
        #1;
        chk("R11 req held", 64'(mem_req_o), 64'd1);
        chk("R11 no array write", 64'(arr_data_we_o), 64'd0);
        chk("R11 addr held", 64'(mem_addr_o), 64'(ea));
        chk("R9 stall while held", 64'(cpu_stall_o), 64'(i == 0 && !t.pf));
        @(negedge clk);
        ack_en = 1'b1;
        #1;
        chk("R11 addr after hold", 64'(mem_addr_o), 64'(ea));
      end else #1;
      chk("R2 fill addr", 64'(mem_addr_o), 64'(ea));
      chk("R1 no write during fill", 64'(mem_we_o), 64'd0);
      chk("R3 array we", 64'(arr_data_we_o), 64'd1);
      chk("R3 array set/way/beat", 64'({arr_set_o, arr_way_o, arr_beat_o}),
          64'({t.addr[12:5], t.way, 2'(t.addr[4:3] + 2'(i))}));
      chk("R3 array data", arr_data_o, {~ea, ea});
      chk("R4 crit pulse", 64'(crit_valid_o), 64'(i == 0));
      chk("R9 stall", 64'(cpu_stall_o), 64'(i == 0 && !t.pf));
      chk("R8 not ready in fill", 64'(req_ready_o), 64'd0);
      chk("R5 tag we", 64'(arr_tag_we_o), 64'(i == 3));
      if (i == 3)
        chk("R5 tag/valid/dirty", 64'({arr_tag_o, arr_valid_o, arr_dirty_o}),
            64'({t.addr[31:13], 1'b1, t.store}));
      @(negedge clk);
    end
    #1;
    chk("R6 lru update", 64'(lru_upd_o), 64'd1);
    chk("R6 lru set/way", 64'({lru_set_o, lru_way_o}), 64'({t.addr[12:5], t.way}));
    chk("R1 no write in lru cycle", 64'(mem_req_o), 64'd0);
    chk("R9 no stall after crit", 64'(cpu_stall_o), 64'd0);
    @(negedge clk);
    if (t.dirty) begin
      for (int k = 0; k < 4; k++) begin
        #1;
        chk("R7 drain write", 64'({mem_req_o, mem_we_o}), 64'd3);
        chk("R7 drain addr", 64'(mem_addr_o), 64'({vt, t.addr[12:5], 2'(k), 3'b000}));
        chk("R7 drain data", mem_wdata_o, vbeat(v, k, t.addr));
        chk("R8 not ready in drain", 64'(req_ready_o), 64'd0);
        chk("R6 lru single pulse", 64'(lru_upd_o), 64'd0);
        if (k == 1) begin
          req_valid = 1'b1;
          req_addr  = 32'hDEAD_BEE0;
          req_dirty = 1'b0;
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      #1;
      chk("R8 blocked request ignored", 64'({mem_req_o, req_ready_o}), 64'd1);
    end else begin
      #1;
      chk("R10 clean: no write, ready", 64'({mem_req_o, mem_we_o, req_ready_o}), 64'd1);
    end
  endtask

  initial begin
    #1;
    chk("R12 reset idle", 64'({req_ready_o, mem_req_o, cpu_stall_o, crit_valid_o, lru_upd_o}),
        64'b10000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 idle after reset", 64'({req_ready_o, mem_req_o, cpu_stall_o}), 64'b100);
    for (int v = 0; v < 6; v++) run_vec(v);
    // reset in the middle of a fill
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0118; req_dirty = 1'b1; req_pf = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk("R9 stall on demand fill", 64'(cpu_stall_o), 64'd1);
    ack_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R12 reset mid-fill", 64'({req_ready_o, mem_req_o, cpu_stall_o, lru_upd_o}),
           64'b1000);
    @(negedge clk);
    rst_n = 1'b1; ack_en = 1'b1;
    #1 chk("R12 buffer empty after reset", 64'({req_ready_o, mem_req_o}), 64'b10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule